// File: doc/BRIEF.md
# NaN-Preserving Precision Converter

This block moves a floating-point NaN between the binary32 and binary64 formats without losing its sign or its payload. The source operand is lifted into an internal canonical form: a sign bit plus the fraction placed flush against the top of a wide payload field. The result is then rebuilt in the target format from that field: the sign, an all-ones exponent, and as many payload bits as the target fraction holds, taken from the top.

A direction input selects widening (binary32 to binary64) or narrowing (binary64 to binary32). A polarity input says whether a fraction MSB of zero or of one marks a signaling NaN. A default-NaN mode input forces every NaN result to the canonical default pattern. The block takes one operation per valid strobe and registers the result one cycle later, along with an invalid flag for signaling inputs. An input that is not a NaN is passed through unchanged, and a flag marks it as not handled.

Top module: `nan_prec_conv`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high. `out_word`, `invalid` and `not_nan` change only on a strobe and hold their values otherwise.
- R2: While reset is active, and until the first strobe after reset, `out_valid`, `out_word`, `invalid` and `not_nan` are all zero.
- R3: The source is `in_word[31:0]` when `narrow`=0 and `in_word[63:0]` when `narrow`=1. It is a NaN when its exponent field (bits 30:23, or bits 62:52) is all ones and its fraction (bits 22:0, or bits 51:0) is nonzero. For a non-NaN source, `out_word` equals the full `in_word`, `not_nan`=1 and `invalid`=0. When widening, `in_word[63:32]` has no effect on a NaN result.
- R4: A NaN source is signaling when its fraction MSB (bit 22, or bit 51) equals `snan_pol`, and quiet otherwise. `invalid`=1 only for a signaling NaN source.
- R5: Widening a NaN gives `{sign, 11'h7FF, frac32, 29'b0}`. The fraction MSB is carried over unchanged, with no quieting.
- R6: Narrowing a NaN gives `{32'b0, sign, 8'hFF, frac64[51:29]}` when `frac64[51:29]` is nonzero.
- R7: Narrowing a NaN whose `frac64[51:29]` is zero gives the binary32 default NaN, never an infinity pattern.
- R8: The default NaN has sign 0 and an all-ones exponent. Its fraction is the MSB alone when `snan_pol`=0, and every bit except the MSB when `snan_pol`=1. That gives 0x7FC00000 / 0x7FBFFFFF for binary32 and 0x7FF8000000000000 / 0x7FF7FFFFFFFFFFFF for binary64. A binary32 result sits in `out_word[31:0]` with the upper half zero.
- R9: With `dflt_mode`=1, every NaN source gives the target's default NaN whatever its payload. `invalid` still follows R4, and non-NaN sources still pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation strobe |
| in_word | input | 64 | Source operand (binary32 in the low half when widening) |
| narrow | input | 1 | 0: binary32 to binary64, 1: binary64 to binary32 |
| snan_pol | input | 1 | Fraction-MSB value that marks a signaling NaN |
| dflt_mode | input | 1 | Force default NaN for every NaN result |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 64 | Converted value, or in_word unchanged for a non-NaN |
| invalid | output | 1 | Source was a signaling NaN |
| not_nan | output | 1 | Source was not a NaN and was passed through |

## Verification
The checker watches the properties that hold on every result, whatever the operand. These are the one-cycle strobe timing, the holding of the outputs between strobes, and the rule that a pass-through never raises invalid. It also checks that every narrowed NaN result has an all-ones exponent and a nonzero fraction, so never an infinity, and that default-NaN mode yields the exact default pattern. The directed scenarios are needed for the payload arithmetic itself. They cover how each bit of the fraction lands in the widened or narrowed word, how the polarity input reclassifies the same word, and the fallback when narrowing truncates the payload to zero.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;
  localparam int unsigned SGL_EXP  = 8;
  localparam int unsigned SGL_FRAC = 23;
  localparam int unsigned DBL_EXP  = 11;
  localparam int unsigned DBL_FRAC = 52;
  localparam int unsigned SGL_W    = 1 + SGL_EXP + SGL_FRAC;
  localparam int unsigned DBL_W    = 1 + DBL_EXP + DBL_FRAC;
  // Canonical payload width: wide enough for the widest fraction.
  localparam int unsigned CANON_W  = (DBL_FRAC > SGL_FRAC) ? DBL_FRAC : SGL_FRAC;

  typedef struct packed {
    logic               sign;
    logic [CANON_W-1:0] payload;
  } canon_nan_t;
endpackage

// File: rtl/nanconv_rst_sync.sv
module nanconv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/nanconv_classify.sv
module nanconv_classify #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              snan_pol,
  output logic              is_nan,
  output logic              is_snan
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f   = word[WORD_W-2 -: EXP_W];
    frac_f  = word[FRAC_W-1:0];
    is_nan  = (&exp_f) && (|frac_f);
    // Signaling when the quiet-bit position carries the polarity value.
    is_snan = is_nan && (frac_f[FRAC_W-1] == snan_pol);
  end
endmodule

// File: rtl/nanconv_to_canon.sv
module nanconv_to_canon
  import nanconv_pkg::*;
#(
  parameter int unsigned FRAC_W = 23
) (
  input  logic              sign,
  input  logic [FRAC_W-1:0] frac,
  output canon_nan_t        canon
);
  localparam int unsigned PAD_W = CANON_W - FRAC_W;

  assign canon.sign = sign;

  generate
    if (PAD_W == 0) begin : g_flush
      assign canon.payload = frac;
    end else begin : g_pad
      assign canon.payload = {frac, {PAD_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/nanconv_from_canon.sv
module nanconv_from_canon #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              sign,
  input  logic [FRAC_W-1:0] mant,
  input  logic              snan_pol,
  input  logic              dflt_mode,
  output logic [WORD_W-1:0] word
);
  logic [FRAC_W-1:0] dflt_frac;
  logic              use_dflt;

  always_comb begin
    dflt_frac = snan_pol ? {1'b0, {(FRAC_W-1){1'b1}}}
                         : {1'b1, {(FRAC_W-1){1'b0}}};
    use_dflt  = dflt_mode || (mant == '0);
    if (use_dflt) word = {1'b0, {EXP_W{1'b1}}, dflt_frac};
    else          word = {sign, {EXP_W{1'b1}}, mant};
  end
endmodule

// File: rtl/nan_prec_conv.sv
module nan_prec_conv
  import nanconv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_word,
  input  logic        narrow,
  input  logic        snan_pol,
  input  logic        dflt_mode,
  output logic        out_valid,
  output logic [63:0] out_word,
  output logic        invalid,
  output logic        not_nan
);
  localparam int unsigned HI_PAD = DBL_W - SGL_W;

  logic rst_q_n;

  nanconv_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // Source views
  logic [SGL_W-1:0] src_s;
  logic [DBL_W-1:0] src_d;
  assign src_s = in_word[SGL_W-1:0];
  assign src_d = in_word;

  logic nan_s, snan_s, nan_d, snan_d;

  nanconv_classify #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRAC)) u_cls_s (
    .word (src_s), .snan_pol (snan_pol), .is_nan (nan_s), .is_snan (snan_s)
  );
  nanconv_classify #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRAC)) u_cls_d (
    .word (src_d), .snan_pol (snan_pol), .is_nan (nan_d), .is_snan (snan_d)
  );

  canon_nan_t canon_s, canon_d, canon_sel;

  nanconv_to_canon #(.FRAC_W(SGL_FRAC)) u_tc_s (
    .sign (src_s[SGL_W-1]), .frac (src_s[SGL_FRAC-1:0]), .canon (canon_s)
  );
  nanconv_to_canon #(.FRAC_W(DBL_FRAC)) u_tc_d (
    .sign (src_d[DBL_W-1]), .frac (src_d[DBL_FRAC-1:0]), .canon (canon_d)
  );

  logic src_nan, src_snan;

  always_comb begin
    canon_sel = narrow ? canon_d : canon_s;
    src_nan   = narrow ? nan_d   : nan_s;
    src_snan  = narrow ? snan_d  : snan_s;
  end

  logic [SGL_W-1:0] res_s;
  logic [DBL_W-1:0] res_d;

  nanconv_from_canon #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRAC)) u_fc_s (
    .sign      (canon_sel.sign),
    .mant      (canon_sel.payload[CANON_W-1 -: SGL_FRAC]),
    .snan_pol  (snan_pol),
    .dflt_mode (dflt_mode),
    .word      (res_s)
  );
  nanconv_from_canon #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRAC)) u_fc_d (
    .sign      (canon_sel.sign),
    .mant      (canon_sel.payload[CANON_W-1 -: DBL_FRAC]),
    .snan_pol  (snan_pol),
    .dflt_mode (dflt_mode),
    .word      (res_d)
  );

  // Next-state
  logic        valid_d, inv_d, nn_d;
  logic [63:0] word_d;

  always_comb begin
    valid_d = in_valid;
    word_d  = out_word;
    inv_d   = invalid;
    nn_d    = not_nan;
    if (in_valid) begin
      if (src_nan) word_d = narrow ? {{HI_PAD{1'b0}}, res_s} : res_d;
      else         word_d = in_word;
      inv_d = src_snan;
      nn_d  = !src_nan;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      invalid   <= 1'b0;
      not_nan   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_word  <= word_d;
      invalid   <= inv_d;
      not_nan   <= nn_d;
    end
  end
endmodule

// File: rtl/nan_prec_conv_chk.sv
module nan_prec_conv_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        in_valid,
  input logic        narrow,
  input logic        snan_pol,
  input logic        dflt_mode,
  input logic        out_valid,
  input logic [63:0] out_word,
  input logic        invalid,
  input logic        not_nan
);
  // R1
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  // R1
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_word) && $stable(invalid) && $stable(not_nan)));

  // R3
  pass_no_invalid_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && not_nan) |-> !invalid);

  // R7
  narrow_never_inf_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !not_nan && $past(narrow)) |->
      (out_word[63:32] == 32'h0 && out_word[30:23] == 8'hFF && out_word[22:0] != 23'h0));

  // R5
  widen_exp_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !not_nan && !$past(narrow)) |->
      (out_word[62:52] == 11'h7FF && out_word[51:0] != 52'h0));

  // R9
  dflt_narrow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !not_nan && $past(narrow) && $past(dflt_mode)) |->
      (out_word == ($past(snan_pol) ? 64'h7FBF_FFFF : 64'h7FC0_0000)));

  // R9
  dflt_widen_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !not_nan && !$past(narrow) && $past(dflt_mode)) |->
      (out_word == ($past(snan_pol) ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h7FF8_0000_0000_0000)));
endmodule

bind nan_prec_conv nan_prec_conv_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .narrow    (narrow),
  .snan_pol  (snan_pol),
  .dflt_mode (dflt_mode),
  .out_valid (out_valid),
  .out_word  (out_word),
  .invalid   (invalid),
  .not_nan   (not_nan)
);

// File: tb/nan_prec_conv_test.sv
module nan_prec_conv_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_word;
  logic        narrow;
  logic        snan_pol;
  logic        dflt_mode;
  logic        out_valid;
  logic [63:0] out_word;
  logic        invalid;
  logic        not_nan;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  nan_prec_conv uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_word (in_word),
    .narrow (narrow), .snan_pol (snan_pol), .dflt_mode (dflt_mode),
    .out_valid (out_valid), .out_word (out_word), .invalid (invalid),
    .not_nan (not_nan)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobe; result sampled at the following falling edge.
  task automatic convert(input string req, input logic [63:0] w, input logic nar,
                         input logic pol, input logic dm, input logic [63:0] exp_w,
                         input logic exp_inv, input logic exp_nn);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; narrow = nar; snan_pol = pol; dflt_mode = dm;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"},   {63'h0, out_valid}, 64'h1);
    check({req, " word"},    out_word, exp_w);
    check({req, " invalid"}, {63'h0, invalid}, {63'h0, exp_inv});
    check({req, " not_nan"}, {63'h0, not_nan}, {63'h0, exp_nn});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; narrow = 1'b0;
    snan_pol = 1'b0; dflt_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 valid", {63'h0, out_valid}, 64'h0);
    check("R2 word",  out_word, 64'h0);
    check("R2 flags", {62'h0, invalid, not_nan}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 after release", {out_word[61:0], out_valid, not_nan}, 64'h0);
  endtask

  task automatic t_passthrough;
    convert("R3 one", 64'hDEAD_BEEF_3F80_0000, 1'b0, 1'b0, 1'b0, 64'hDEAD_BEEF_3F80_0000, 1'b0, 1'b1);
    convert("R3 inf32", 64'h0000_0000_7F80_0000, 1'b0, 1'b0, 1'b0, 64'h0000_0000_7F80_0000, 1'b0, 1'b1);
    convert("R3 inf64", 64'hFFF0_0000_0000_0000, 1'b1, 1'b0, 1'b0, 64'hFFF0_0000_0000_0000, 1'b0, 1'b1);
    convert("R3 R9 dflt", 64'h4000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 64'h4000_0000_0000_0000, 1'b0, 1'b1);
  endtask

  task automatic t_widen;
    convert("R5 quiet", 64'h1234_5678_FFC1_2345, 1'b0, 1'b0, 1'b0,
            {1'b1, 11'h7FF, 23'h412345, 29'h0}, 1'b0, 1'b0);
    convert("R4 R5 snan", 64'h0000_0000_7F80_0001, 1'b0, 1'b0, 1'b0,
            {1'b0, 11'h7FF, 23'h000001, 29'h0}, 1'b1, 1'b0);
    convert("R4 pol1 quiet", 64'h0000_0000_7F80_0001, 1'b0, 1'b1, 1'b0,
            {1'b0, 11'h7FF, 23'h000001, 29'h0}, 1'b0, 1'b0);
    convert("R4 pol1 snan", 64'h0000_0000_7FC0_0000, 1'b0, 1'b1, 1'b0,
            {1'b0, 11'h7FF, 23'h400000, 29'h0}, 1'b1, 1'b0);
  endtask

  task automatic t_narrow;
    logic [63:0] w;
    w = 64'hFFFC_A000_0000_0000;
    convert("R6 payload", w, 1'b1, 1'b0, 1'b0, {32'h0, w[63], 8'hFF, w[51:29]}, 1'b0, 1'b0);
    w = 64'h7FF0_0000_2000_0000;
    convert("R4 R6 low bit", w, 1'b1, 1'b0, 1'b0, {32'h0, 1'b0, 8'hFF, 23'h000001}, 1'b1, 1'b0);
    convert("R7 R8 trunc pol0", 64'h7FF0_0000_0000_0001, 1'b1, 1'b0, 1'b0, 64'h7FC0_0000, 1'b1, 1'b0);
    convert("R7 R8 trunc pol1", 64'hFFF0_0000_1FFF_FFFF, 1'b1, 1'b1, 1'b0, 64'h7FBF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_default_mode;
    convert("R9 R8 widen pol0", 64'h0000_0000_FF81_2345, 1'b0, 1'b0, 1'b1, 64'h7FF8_0000_0000_0000, 1'b1, 1'b0);
    convert("R9 R8 widen pol1", 64'h0000_0000_FFC1_2345, 1'b0, 1'b1, 1'b1, 64'h7FF7_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    convert("R9 narrow pol1", 64'h7FF0_0000_1000_0000, 1'b1, 1'b1, 1'b1, 64'h7FBF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_hold;
    convert("R1 setup", 64'h0000_0000_FFC0_0001, 1'b0, 1'b0, 1'b0,
            {1'b1, 11'h7FF, 23'h400001, 29'h0}, 1'b0, 1'b0);
    in_word = 64'h7FF0_0000_0000_0001; narrow = 1'b1; dflt_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle valid", {63'h0, out_valid}, 64'h0);
    check("R1 hold word", out_word, {1'b1, 11'h7FF, 23'h400001, 29'h0});
    check("R1 hold flags", {62'h0, invalid, not_nan}, 64'h0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    t_reset();
    t_passthrough();
    t_widen();
    t_narrow();
    t_default_mode();
    t_hold();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule